// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches a vector of general-purpose input lines and turns chosen activity on them into interrupt status. Each line is set up on its own. A sense bit selects edge or level detection. A polarity bit selects rising or falling edge, or high or low level. In edge mode, a both-edges bit lets any change count, whatever the polarity says. Edge events come only from lines that the direction vector marks as inputs.

Events set bits in a sticky raw status register. Software reads the raw view or the masked view and clears bits by writing ones. A single registered interrupt line is high while any unmasked status bit is set. The block samples the current pin vector, the previous pin vector and the direction vector once per clock and compares the samples. Configuration and status sit behind a simple register port. Writes take effect on the clock edge. Reads return data one cycle after the request.

Top module: `gpio_irq_detect`

## Requirements
- R1: While `rst` is high at a clock edge, sense, both-edges, polarity, mask and raw status all become 0 and `irq_out` becomes 0. After reset, every readable register reads 0.
- R2: These offsets are read/write, each holding LINES bits that read back in bits [LINES-1:0]: sense at 0x404, both-edges at 0x408, polarity at 0x40C and mask at 0x410. Any unmapped offset (for example 0x400) reads 0.
- R3: A line with sense 0, direction 0 and both-edges 1 sets its raw bit on any change between its previous and current sample.
- R4: A line with sense 0, direction 0 and both-edges 0 sets its raw bit on a change only if its new level equals its polarity bit. Polarity 1 means rising and polarity 0 means falling.
- R5: A line whose direction bit is 1 (output) never sets its raw bit through edge detection.
- R6: A line with sense 1 sets its raw bit on every cycle in which its sampled level equals its polarity bit, whatever its direction bit. The bit therefore comes back right after a clear while that level persists.
- R7: Raw status bits are sticky. Writing to the clear register at 0x41C clears each raw bit whose write-data bit is 1 and leaves the rest unchanged. Reading 0x41C returns 0.
- R8: Raw status reads at 0x414 and masked status (raw AND mask) reads at 0x418. Writes to either offset change nothing.
- R9: `irq_out` is 1 exactly when raw status AND mask is nonzero. It updates on the same clock edge as the raw status and the mask.
- R10: When a clear and a new event hit the same bit on the same edge, the bit ends up set.
- R11: A pin change presented before clock edge k is sampled at edge k and shows in raw status and `irq_out` after edge k+1. Read data is registered and valid in the cycle after `bus_ren`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_now | input | LINES | Current level of each line |
| pin_prev | input | LINES | Level of each line one step earlier |
| pin_dir | input | LINES | Direction per line, 1 = output |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | DATA_W | Registered read data, zero-extended |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The assertions assume that `pin_prev` and `pin_now` describe the same lines. They also assume that reads and writes are single-cycle strobes on a registered port, and that any reset lasts at least one clock edge. The bench drives every input on the falling clock edge and holds a pin change for exactly one sampled cycle, then sets the previous vector equal to the current one. Because of this, each edge is counted once and the bench never produces a change it does not expect. Configuration is always changed before raw status is cleared. Stale events from the previous setup are therefore wiped before a new pattern is applied.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Register offsets; the clear offset and the status offsets are decoded by
  // software drivers, so their positions are part of the block's behaviour.
  localparam logic [11:0] OFS_SENSE  = 12'h404;
  localparam logic [11:0] OFS_BOTH   = 12'h408;
  localparam logic [11:0] OFS_POL    = 12'h40C;
  localparam logic [11:0] OFS_MASK   = 12'h410;
  localparam logic [11:0] OFS_RAW    = 12'h414;
  localparam logic [11:0] OFS_MSKD   = 12'h418;
  localparam logic [11:0] OFS_CLEAR  = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SENSE,
    SEL_BOTH,
    SEL_POL,
    SEL_MASK,
    SEL_RAW,
    SEL_MSKD,
    SEL_CLEAR
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sampler.sv
// Registers the pin vectors so detection works on a stable, single-domain copy.
module gpio_irq_sampler #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] pin_now,
  input  logic [LINES-1:0] pin_prev,
  input  logic [LINES-1:0] pin_dir,
  output logic [LINES-1:0] now_s,
  output logic [LINES-1:0] chg_s,
  output logic [LINES-1:0] dir_s
);
  always_ff @(posedge clk) begin
    if (rst) begin
      now_s <= '0;
      chg_s <= '0;
      dir_s <= '0;
    end else begin
      now_s <= pin_now;
      chg_s <= pin_now ^ pin_prev;
      dir_s <= pin_dir;
    end
  end
endmodule

// File: rtl/gpio_irq_cfg.sv
// Configuration registers, clear strobe decode and registered read path.
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  input  logic [LINES-1:0]  raw_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LINES-1:0]  sense_q,
  output logic [LINES-1:0]  both_q,
  output logic [LINES-1:0]  pol_q,
  output logic [LINES-1:0]  mask_q,
  output logic [LINES-1:0]  mask_d,
  output logic              clr_wr,
  output logic [LINES-1:0]  clr_bits
);
  localparam int PAD_W = DATA_W - LINES;

  reg_sel_e         sel;
  logic [LINES-1:0] sense_d, both_d, pol_d;
  logic [LINES-1:0] rd_mux;

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFS_SENSE)) sel = SEL_SENSE;
    else if (bus_addr == ADDR_W'(OFS_BOTH))  sel = SEL_BOTH;
    else if (bus_addr == ADDR_W'(OFS_POL))   sel = SEL_POL;
    else if (bus_addr == ADDR_W'(OFS_MASK))  sel = SEL_MASK;
    else if (bus_addr == ADDR_W'(OFS_RAW))   sel = SEL_RAW;
    else if (bus_addr == ADDR_W'(OFS_MSKD))  sel = SEL_MSKD;
    else if (bus_addr == ADDR_W'(OFS_CLEAR)) sel = SEL_CLEAR;
  end

  always_comb begin
    sense_d = sense_q;
    both_d  = both_q;
    pol_d   = pol_q;
    mask_d  = mask_q;
    if (bus_wen) begin
      unique case (sel)
        SEL_SENSE: sense_d = bus_wdata;
        SEL_BOTH:  both_d  = bus_wdata;
        SEL_POL:   pol_d   = bus_wdata;
        SEL_MASK:  mask_d  = bus_wdata;
        default: ;
      endcase
    end
  end

  assign clr_wr   = bus_wen && (sel == SEL_CLEAR);
  assign clr_bits = clr_wr ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else begin
      sense_q <= sense_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
      mask_q  <= mask_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_SENSE: rd_mux = sense_q;
      SEL_BOTH:  rd_mux = both_q;
      SEL_POL:   rd_mux = pol_q;
      SEL_MASK:  rd_mux = mask_q;
      SEL_RAW:   rd_mux = raw_q;
      SEL_MSKD:  rd_mux = raw_q & mask_q;
      default:   rd_mux = '0;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_ff @(posedge clk) begin
        if (rst || !bus_ren) bus_rdata <= '0;
        else                 bus_rdata <= {{PAD_W{1'b0}}, rd_mux};
      end
    end else begin : g_nopad
      always_ff @(posedge clk) begin
        if (rst || !bus_ren) bus_rdata <= '0;
        else                 bus_rdata <= rd_mux[DATA_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_line.sv
// Detection and sticky status for a single line.
module gpio_irq_line (
  input  logic clk,
  input  logic rst,
  input  logic now_s,
  input  logic chg_s,
  input  logic dir_s,
  input  logic sense,
  input  logic both,
  input  logic pol,
  input  logic clr,
  output logic hit,
  output logic raw_d,
  output logic raw_q
);
  logic level_match;
  logic edge_hit;
  logic lvl_hit;

  assign level_match = ~(now_s ^ pol);
  assign edge_hit    = ~sense & ~dir_s & chg_s & (both | level_match);
  assign lvl_hit     = sense & level_match;
  assign hit         = edge_hit | lvl_hit;
  // a fresh event takes precedence over a clear on the same edge
  assign raw_d       = hit | (raw_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else     raw_q <= raw_d;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  pin_now,
  input  logic [LINES-1:0]  pin_prev,
  input  logic [LINES-1:0]  pin_dir,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic [LINES-1:0] now_s, chg_s, dir_s;
  logic [LINES-1:0] sense_q, both_q, pol_q, mask_q, mask_d;
  logic [LINES-1:0] clr_bits;
  logic             clr_wr;
  logic [LINES-1:0] hit, raw_d, raw_q;

  gpio_irq_sampler #(.LINES(LINES)) u_smp (
    .clk(clk), .rst(rst),
    .pin_now(pin_now), .pin_prev(pin_prev), .pin_dir(pin_dir),
    .now_s(now_s), .chg_s(chg_s), .dir_s(dir_s)
  );

  gpio_irq_cfg #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst),
    .bus_wen(bus_wen), .bus_ren(bus_ren), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .raw_q(raw_q), .bus_rdata(bus_rdata),
    .sense_q(sense_q), .both_q(both_q), .pol_q(pol_q),
    .mask_q(mask_q), .mask_d(mask_d),
    .clr_wr(clr_wr), .clr_bits(clr_bits)
  );

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      gpio_irq_line u_line (
        .clk(clk), .rst(rst),
        .now_s(now_s[i]), .chg_s(chg_s[i]), .dir_s(dir_s[i]),
        .sense(sense_q[i]), .both(both_q[i]), .pol(pol_q[i]),
        .clr(clr_bits[i]),
        .hit(hit[i]), .raw_d(raw_d[i]), .raw_q(raw_q[i])
      );
    end
  endgenerate

  // registered from next-state so the line moves on the same edge as status
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(raw_d & mask_d);
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_out,
  input logic [LINES-1:0] raw_q,
  input logic [LINES-1:0] mask_q,
  input logic [LINES-1:0] sense_q,
  input logic [LINES-1:0] dir_s,
  input logic [LINES-1:0] hit,
  input logic             clr_wr
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (raw_q == '0 && mask_q == '0 && !irq_out));

  a_r9_irq_tracks_masked: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(raw_q & mask_q));

  a_r7_raw_sticky: assert property (@(posedge clk) disable iff (rst)
    (!clr_wr) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  a_r5_outputs_no_edge: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((raw_q & ~$past(raw_q) & $past(dir_s & ~sense_q)) == '0));

  a_r10_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && (hit != '0)) |=> ((raw_q & $past(hit)) == $past(hit)));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .raw_q(raw_q), .mask_q(mask_q),
  .sense_q(sense_q), .dir_s(dir_s), .hit(hit), .clr_wr(clr_wr)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin_now = '0, pin_prev = '0, pin_dir = '0;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  gpio_irq_detect dut (
    .clk(clk), .rst(rst), .pin_now(pin_now), .pin_prev(pin_prev),
    .pin_dir(pin_dir), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // {sense, both, pol, dir, prev, now, expected raw}
  localparam logic [55:0] VEC [0:6] = '{
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF}, // R4 rising
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00}, // R4 falling vs rising change
    {8'h00, 8'hFF, 8'h00, 8'h0F, 8'hA5, 8'h5A, 8'hF0}, // R3 + R5 outputs ignored
    {8'h00, 8'h00, 8'h0F, 8'h00, 8'h3C, 8'hC3, 8'h33}, // R4 mixed polarity
    {8'hFF, 8'h00, 8'hF0, 8'hFF, 8'hAA, 8'hAA, 8'hA5}, // R6 level, outputs too
    {8'h0F, 8'h00, 8'h33, 8'h00, 8'h00, 8'hFF, 8'h3F}, // R6 + R4 mixed sense
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'h55, 8'h55, 8'h00}  // R3 no change, no event
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] p, input logic [7:0] n);
    @(negedge clk);
    pin_prev = p; pin_now = n;
    @(negedge clk);
    pin_prev = n;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    check("R1 rdata idle", bus_rdata, 32'd0);
    bus_read(12'h404, rd); check("R1 sense", rd, 0);
    bus_read(12'h410, rd); check("R1 mask", rd, 0);
    bus_read(12'h414, rd); check("R1 raw", rd, 0);
    // R2 register map read-back
    bus_write(12'h404, 8'h96); bus_read(12'h404, rd); check("R2 sense", rd, 32'h96);
    bus_write(12'h408, 8'h3C); bus_read(12'h408, rd); check("R2 both", rd, 32'h3C);
    bus_write(12'h40C, 8'hC5); bus_read(12'h40C, rd); check("R2 pol", rd, 32'hC5);
    bus_write(12'h410, 8'h81); bus_read(12'h410, rd); check("R2 mask", rd, 32'h81);
    bus_write(12'h400, 8'hFF); bus_read(12'h400, rd); check("R2 unmapped", rd, 0);

    // table walk: R3 R4 R5 R6 R9
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      pin_prev = VEC[i][23:16]; pin_now = VEC[i][23:16]; pin_dir = VEC[i][31:24];
      bus_write(12'h404, VEC[i][55:48]);
      bus_write(12'h408, VEC[i][47:40]);
      bus_write(12'h40C, VEC[i][39:32]);
      bus_write(12'h410, 8'hFF);
      bus_write(12'h41C, 8'hFF);
      tick(2);
      pulse(VEC[i][23:16], VEC[i][15:8]);
      tick(1);
      bus_read(12'h414, rd);
      check($sformatf("R3/R4/R5/R6 vector %0d raw", i), rd, {24'd0, VEC[i][7:0]});
      check($sformatf("R9 vector %0d irq", i), {31'd0, irq_out}, {31'd0, VEC[i][7:0] != 8'h00});
    end

    // R11 timing of an edge
    @(negedge clk); pin_dir = 8'h00; pin_prev = 8'h00; pin_now = 8'h00;
    bus_write(12'h404, 8'h00); bus_write(12'h408, 8'hFF);
    bus_write(12'h410, 8'hFF); bus_write(12'h41C, 8'hFF);
    tick(2);
    @(negedge clk); pin_now = 8'h01;
    @(negedge clk); pin_prev = 8'h01;
    check("R11 not yet raised", {31'd0, irq_out}, 0);
    @(negedge clk);
    check("R11 raised after second edge", {31'd0, irq_out}, 1);

    // R8 / R9 masking
    bus_write(12'h41C, 8'hFF); tick(1);
    pulse(8'h01, 8'h0E); tick(1);   // bits 0..3 change
    bus_write(12'h410, 8'hF0);
    check("R9 masked off", {31'd0, irq_out}, 0);
    bus_read(12'h418, rd); check("R8 masked view empty", rd, 0);
    bus_write(12'h410, 8'h04);
    check("R9 one bit unmasked", {31'd0, irq_out}, 1);
    bus_read(12'h418, rd); check("R8 masked view", rd, 32'h04);
    bus_write(12'h414, 8'hFF); bus_write(12'h418, 8'hFF);
    bus_read(12'h414, rd); check("R8 status writes ignored", rd, 32'h0F);

    // R7 selective clear
    bus_write(12'h41C, 8'h05); bus_read(12'h414, rd); check("R7 clear ones", rd, 32'h0A);
    bus_write(12'h41C, 8'h00); bus_read(12'h414, rd); check("R7 zeros keep", rd, 32'h0A);
    bus_read(12'h41C, rd); check("R7 clear reads zero", rd, 0);

    // R10 event and clear on the same edge
    @(negedge clk); pin_prev = 8'h0E; pin_now = 8'h0F;  // bit0 rising, both-edges on
    @(negedge clk); pin_prev = 8'h0F;
    bus_wen = 1'b1; bus_addr = 12'h41C; bus_wdata = 8'hFF;
    @(negedge clk); bus_wen = 1'b0;
    bus_read(12'h414, rd); check("R10 event wins", rd, 32'h01);

    // R6 level re-assert on an output line
    @(negedge clk); pin_dir = 8'h01; pin_prev = 8'h01; pin_now = 8'h01;
    bus_write(12'h404, 8'h01); bus_write(12'h40C, 8'h01);
    bus_write(12'h41C, 8'hFF); tick(1);
    bus_read(12'h414, rd); check("R6 level persists after clear", rd, 32'h01);
    bus_write(12'h40C, 8'h00); bus_write(12'h41C, 8'hFF); tick(1);
    bus_read(12'h414, rd); check("R6 level gone", rd, 0);

    // R1 reset in mid operation
    bus_write(12'h40C, 8'h01); bus_write(12'h410, 8'hFF); tick(1);
    check("R1 precondition irq", {31'd0, irq_out}, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; pin_now = 8'h00; pin_prev = 8'h00;
    check("R1 irq cleared", {31'd0, irq_out}, 0);
    bus_read(12'h414, rd); check("R1 raw cleared", rd, 0);
    bus_read(12'h410, rd); check("R1 mask cleared", rd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule